// File: doc/BRIEF.md
# SPI Controller Status and Mode Flags

This block holds the status word of an SPI controller: a run/configuration mode bit, a master-select bit, and six sticky error flags. The error flags are transmit overflow, receive overflow, abort, transmit underflow, receive underflow and mode error. Hardware raises an error flag with a one-cycle event pulse. For the first five flags, the pulse counts only while the matching error-enable bit is high. Software never writes the status word. Instead, it writes a command word that has one set bit and one clear bit for each flag. A level-sensitive error interrupt stays high while any error flag is set.

The mode bit is a two-state machine. `MODE_CFG` is configuration mode and is entered at reset. `MODE_RUN` is run mode. The transition `CFG->RUN` is taken on a command with only the set-enable bit. The transition `RUN->CFG` is taken on a command with only the clear-enable bit. Any other command leaves the state as it is. Software can clear every error flag with the single command value 0x0F50, and this leaves the mode and master bits unchanged.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset, status bits 0..12 are 0 and `err_irq_o` is 0.
- R2: A command (strobe high) with bit 1 set and bit 0 clear enters run mode, so status bit 0 reads 1 from the next cycle. Bit 0 set with bit 1 clear enters configuration mode, so status bit 0 reads 0.
- R3: Command bit 3 sets the master-select flag and command bit 2 clears it. The flag appears at status bit 1 from the next cycle.
- R4: A pulse on `hw_evt[i]` sets its error flag in the next cycle when `ctrl_err_en[i]` is 1. The indices are 0 transmit overflow (status bit 8), 1 receive overflow (bit 9), 2 abort (bit 10), 3 transmit underflow (bit 11) and 4 receive underflow (bit 12).
- R5: A pulse on `hw_evt[i]` for i in 0..4 while `ctrl_err_en[i]` is 0 leaves the flag unchanged.
- R6: `hw_evt[5]` sets the mode error flag (status bit 7) whatever the enables are.
- R7: Software sets and clears the error flags with command bit pairs (clear/set): transmit overflow 8/12, receive overflow 9/13, abort 10/14, transmit underflow 11/15, receive underflow 4/5, mode error 6/7. While the strobe is low, the command word has no effect.
- R8: When a set bit and its matching clear bit arrive together, that flag (mode and master included) keeps its value.
- R9: The command 0x0F50 clears all six error flags in one write and leaves the mode and master bits unchanged.
- R10: An enabled hardware event in the same cycle as a software clear of the same flag leaves the flag set.
- R11: `err_irq_o` is high exactly while at least one error flag is set.
- R12: Status bit 13 follows `busy_in` in the same cycle. Bits 2..6, 14 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | 16 | Command word of set/clear bit pairs |
| ctrl_err_en | input | 5 | Error-enable bits for flags 0..4 |
| hw_evt | input | 6 | Hardware error event pulses |
| busy_in | input | 1 | Transfer-in-progress indication |
| status_o | output | 16 | Status word |
| err_irq_o | output | 1 | Level error interrupt |

## Verification
The assertions expect event pulses and command strobes to be stable single-cycle values that are sampled at the rising edge. They also expect `busy_in` to come from outside and never to feed the flags. The stimulus changes inputs only on falling edges and holds each one for exactly one cycle. It covers collisions on purpose: a set together with a clear, an event together with a clear, and a disabled event together with an idle command. These are the antecedents the properties guard. A reference model in the bench predicts every status word and interrupt level.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int unsigned NUM_ERR   = 6;
    localparam int unsigned NUM_GATED = 5;
    localparam int unsigned CMD_W     = 16;
    localparam int unsigned STAT_W    = 16;

    localparam int unsigned CMD_CLR_EN  = 0;
    localparam int unsigned CMD_SET_EN  = 1;
    localparam int unsigned CMD_CLR_MS  = 2;
    localparam int unsigned CMD_SET_MS  = 3;
    localparam int unsigned STAT_EN_BIT = 0;
    localparam int unsigned STAT_MS_BIT = 1;
    localparam int unsigned STAT_BSY_BIT = 13;

    localparam int unsigned ERR_CLR_BIT  [NUM_ERR] = '{8, 9, 10, 11, 4, 6};
    localparam int unsigned ERR_SET_BIT  [NUM_ERR] = '{12, 13, 14, 15, 5, 7};
    localparam int unsigned ERR_STAT_BIT [NUM_ERR] = '{8, 9, 10, 11, 12, 7};

    typedef enum logic {
        MODE_CFG = 1'b0,
        MODE_RUN = 1'b1
    } mode_e;
endpackage

// File: rtl/spi_sticky_bit.sv
module spi_sticky_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic q
);
    logic q_next;

    always_comb begin
        q_next = q;
        if (hw_set)
            q_next = 1'b1;
        else if (sw_set && !sw_clr)
            q_next = 1'b1;
        else if (sw_clr && !sw_set)
            q_next = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_next;
    end

    assert_hw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);
    assert_evt_beats_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && sw_clr) |=> q);
    assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && sw_clr && !hw_set) |=> $stable(q));
    assert_sw_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !sw_set && !hw_set) |=> !q);
endmodule

// File: rtl/spi_mode_fsm.sv
module spi_mode_fsm
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_run,
    input  logic go_cfg,
    output logic run_o
);
    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CFG: if (go_run && !go_cfg) state_d = MODE_RUN;
            MODE_RUN: if (go_cfg && !go_run) state_d = MODE_CFG;
            default:  state_d = MODE_CFG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_CFG;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o = (state_q == MODE_RUN);
    end

    assert_enter_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_run && !go_cfg) |=> run_o);
    assert_enter_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cfg && !go_run) |=> !run_o);
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_run == go_cfg) |=> $stable(run_o));
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
    import spi_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_we,
    input  logic [CMD_W-1:0]     cmd_data,
    input  logic [NUM_GATED-1:0] ctrl_err_en,
    input  logic [NUM_ERR-1:0]   hw_evt,
    input  logic                 busy_in,
    output logic [STAT_W-1:0]    status_o,
    output logic                 err_irq_o
);
    logic [NUM_ERR-1:0] en_vec;
    logic [NUM_ERR-1:0] hw_set;
    logic [NUM_ERR-1:0] err_q;
    logic               run_q;
    logic               ms_q;

    assign en_vec = {1'b1, ctrl_err_en};

    spi_mode_fsm i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_run (cmd_we & cmd_data[CMD_SET_EN]),
        .go_cfg (cmd_we & cmd_data[CMD_CLR_EN]),
        .run_o  (run_q)
    );

    spi_sticky_bit #(.RST_VAL(1'b0)) i_master (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (1'b0),
        .sw_set (cmd_we & cmd_data[CMD_SET_MS]),
        .sw_clr (cmd_we & cmd_data[CMD_CLR_MS]),
        .q      (ms_q)
    );

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        assign hw_set[i] = hw_evt[i] & en_vec[i];

        spi_sticky_bit #(.RST_VAL(1'b0)) i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[i]),
            .sw_set (cmd_we & cmd_data[ERR_SET_BIT[i]]),
            .sw_clr (cmd_we & cmd_data[ERR_CLR_BIT[i]]),
            .q      (err_q[i])
        );

        if (i < NUM_GATED) begin : g_gated
            assert_masked_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_evt[i] && !ctrl_err_en[i] && !cmd_we) |=> $stable(err_q[i]));
        end
    end

    always_comb begin
        status_o = '0;
        status_o[STAT_EN_BIT]  = run_q;
        status_o[STAT_MS_BIT]  = ms_q;
        status_o[STAT_BSY_BIT] = busy_in;
        for (int k = 0; k < NUM_ERR; k++)
            status_o[ERR_STAT_BIT[k]] = err_q[k];
    end

    assign err_irq_o = |err_q;

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 16'h0F50 && hw_set == '0) |=> !err_irq_o);
    assert_clear_all_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 16'h0F50) |=> ($stable(run_q) && $stable(ms_q)));
    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_irq_o && hw_set == '0 && !cmd_we) |=> !err_irq_o);
endmodule

// File: tb/test_spi_stat_ctrl.sv
module test_spi_stat_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [4:0]  ctrl_err_en = '0;
    logic [5:0]  hw_evt = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_o;
    logic        err_irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    // reference state
    logic       m_en = 0, m_ms = 0;
    logic [5:0] m_err = '0;

    always #2 clk = ~clk;

    spi_stat_ctrl i_spi_stat_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .ctrl_err_en(ctrl_err_en), .hw_evt(hw_evt), .busy_in(busy_in),
        .status_o(status_o), .err_irq_o(err_irq_o)
    );

    function automatic logic upd(logic cur, logic hw, logic s, logic c);
        if (hw) return 1'b1;
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return cur;
    endfunction

    task automatic step(input logic we, input logic [15:0] cmd, input logic [4:0] en,
                        input logic [5:0] evt, input logic bsy, input string tag);
        logic [15:0] s_exp;
        logic [5:0]  sb, cb, enx;
        @(negedge clk);
        cmd_we = we; cmd_data = cmd; ctrl_err_en = en; hw_evt = evt; busy_in = bsy;
        sb  = we ? {cmd[7], cmd[5], cmd[15], cmd[14], cmd[13], cmd[12]} : 6'b0;
        cb  = we ? {cmd[6], cmd[4], cmd[11], cmd[10], cmd[9], cmd[8]} : 6'b0;
        enx = {1'b1, en};
        m_en = upd(m_en, 1'b0, we & cmd[1], we & cmd[0]);
        m_ms = upd(m_ms, 1'b0, we & cmd[3], we & cmd[2]);
        for (int i = 0; i < 6; i++)
            m_err[i] = upd(m_err[i], evt[i] & enx[i], sb[i], cb[i]);
        s_exp = '0;
        s_exp[0] = m_en; s_exp[1] = m_ms; s_exp[13] = bsy;
        s_exp[12:8] = m_err[4:0]; s_exp[7] = m_err[5];
        exp_q.push_back({|m_err, s_exp});
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        logic [16:0] e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({err_irq_o, status_o} !== e) begin
                    fails++;
                    $display("FAIL %s actual irq=%b status=%h expected irq=%b status=%h",
                             t, err_irq_o, status_o, e[16], e[15:0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1 reset state
        if (status_o[12:0] !== 13'h0 || err_irq_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 actual status=%h irq=%b expected status=0000 irq=0", status_o, err_irq_o);
        end
        @(negedge clk); rst_n = 1'b1;

        step(0, 16'h0000, 5'h00, 6'h00, 1, "R12 busy high");
        step(0, 16'h0000, 5'h00, 6'h00, 0, "R1 idle after reset");
        step(1, 16'h0002, 5'h00, 6'h00, 0, "R2 enter run");
        step(1, 16'h0003, 5'h00, 6'h00, 0, "R8 mode set+clear hold");
        step(0, 16'h0001, 5'h00, 6'h00, 0, "R7 strobe low ignored");
        step(1, 16'h0001, 5'h00, 6'h00, 0, "R2 enter config");
        step(1, 16'h0008, 5'h00, 6'h00, 1, "R3 master set");
        step(1, 16'h000C, 5'h00, 6'h00, 0, "R8 master pair hold");
        step(1, 16'h0004, 5'h00, 6'h00, 0, "R3 master clear");
        step(1, 16'h000A, 5'h00, 6'h00, 0, "R2 run and master");
        for (int i = 0; i < 5; i++) begin
            step(0, 16'h0000, 5'h1F, 6'(1 << i), 0, "R4 enabled event");
            step(1, 16'h0F50, 5'h1F, 6'h00, 0, "R9 clear all");
            step(0, 16'h0000, 5'h1F, 6'h00, 0, "R11 irq low after clear");
        end
        step(0, 16'h0000, 5'h00, 6'h1F, 0, "R5 disabled events");
        step(0, 16'h0000, 5'h1E, 6'h01, 0, "R5 one disabled event");
        step(0, 16'h0000, 5'h00, 6'h20, 0, "R6 mode error event");
        step(1, 16'h0040, 5'h00, 6'h00, 0, "R7 mode error clear");
        step(1, 16'hF0A0, 5'h00, 6'h00, 0, "R7 set all by software");
        step(1, 16'h0F50, 5'h00, 6'h00, 1, "R9 clear all keeps mode");
        step(1, 16'h1000, 5'h00, 6'h00, 0, "R7 set tx overflow");
        step(1, 16'h1100, 5'h00, 6'h00, 0, "R8 set+clear hold high");
        step(1, 16'h0100, 5'h00, 6'h00, 0, "R7 clear tx overflow");
        step(1, 16'h2200, 5'h00, 6'h00, 0, "R8 set+clear hold low");
        step(1, 16'h0030, 5'h00, 6'h00, 0, "R8 rx underflow pair hold");
        step(0, 16'h0000, 5'h04, 6'h04, 0, "R11 abort raises irq");
        step(1, 16'h0400, 5'h04, 6'h04, 0, "R10 event beats clear");
        step(1, 16'h0010, 5'h10, 6'h10, 0, "R10 rx underflow beats clear");
        step(1, 16'h0F50, 5'h00, 6'h00, 0, "R9 final clear");
        step(0, 16'h0000, 5'h00, 6'h00, 0, "R11 irq level low");
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule